// File: doc/BRIEF.md
# SPI NOR Flash Command Monitor

This block observes an SPI flash bus one byte at a time and turns what it sees into decoded events. An upstream deserializer presents, on a single-cycle strobe, the byte shifted out by the controller and the byte shifted back by the flash, together with the level of the chip-select. The monitor never drives the bus. It takes the first byte of every selected frame as an opcode, then follows the byte sequence that the opcode implies: address capture, dummy skipping, reply ordering and data counting.

Each decoded item appears on its own valid pulse, one clock after the strobe that carried it. The events are an opcode, an unknown opcode, a completed address, a data byte with its running address, an identification byte, a status byte, and three warnings: a misaligned sector erase, a program or erase issued without a preceding write enable, and a frame that ended before its address was complete. The block is meant for protocol checkers, trace capture and bus debug logic.

Top module: `spi_flash_monitor`

## Requirements
- R1: In a selected frame, the first strobe whose controller byte is a supported opcode (0x06, 0x04, 0x9F, 0x05, 0x01, 0x03, 0x0B, 0x20, 0xD8, 0x60, 0xC7, 0x02, 0x90) pulses op_vld_o with op_o equal to that byte on the following cycle.
- R2: An unsupported first byte pulses unk_o instead of op_vld_o, and the next strobe in the same frame is again taken as an opcode.
- R3: For read (0x03), fast read (0x0B), page program (0x02) and sector erase (0x20), controller bytes 2, 3 and 4 form a 24-bit address, most significant byte first; addr_vld_o pulses with addr_o equal to it one cycle after byte 4.
- R4: Data bytes come from the flash side for read from byte 5, from the flash side for fast read from byte 6 with byte 5 a dummy that raises no event, and from the controller side for page program from byte 5.
- R5: data_addr_o of the first data byte equals the captured address and rises by one per data byte, wrapping from 0xFFFFFF to 0x000000.
- R6: A sector erase whose address has any of bits 11:0 set pulses warn_align_o in the same cycle as its addr_vld_o.
- R7: Write enable (0x06) sets an internal latch and write disable (0x04) clears it; an opcode of 0x02, 0x20, 0xD8, 0x60 or 0xC7 seen with the latch clear pulses warn_wren_o; the end of a frame carrying one of those opcodes clears the latch.
- R8: For the JEDEC ID read (0x9F), flash bytes 2, 3 and 4 pulse id_vld_o with id_sel_o 0 (manufacturer), 1 (memory type) and 2 (device); later bytes raise no event.
- R9: For the manufacturer/device ID read (0x90), bytes 2 and 3 are ignored, controller byte 4 equal to 0x00 puts the manufacturer first and any other value the device first; flash bytes 5 and 6 pulse id_vld_o with id_sel_o 0 or 2 in that order.
- R10: For the status read (0x05), every flash byte after the opcode pulses stat_vld_o with stat_o equal to it for as long as the frame lasts.
- R11: Chip-select low ends the current command; if it was one of the four address commands and fewer than three address bytes had arrived, warn_trunc_o pulses one cycle later.
- R12: Strobes while chip-select is low raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_active_i | input | 1 | Chip-select level, 1 while the flash is selected |
| byte_vld_i | input | 1 | Strobe: one byte pair is present |
| mosi_byte_i | input | 8 | Byte sent by the controller |
| miso_byte_i | input | 8 | Byte returned by the flash |
| op_vld_o | output | 1 | Supported opcode seen |
| op_o | output | 8 | Last opcode |
| unk_o | output | 1 | Unsupported opcode seen |
| addr_vld_o | output | 1 | Address complete |
| addr_o | output | 24 | Captured address |
| data_vld_o | output | 1 | Data byte seen |
| data_o | output | 8 | Data byte |
| data_addr_o | output | 24 | Address of the data byte |
| id_vld_o | output | 1 | Identification byte seen |
| id_sel_o | output | 2 | 0 manufacturer, 1 memory type, 2 device |
| id_o | output | 8 | Identification byte |
| stat_vld_o | output | 1 | Status byte seen |
| stat_o | output | 8 | Status byte |
| warn_align_o | output | 1 | Sector erase address not on a 4 KiB boundary |
| warn_wren_o | output | 1 | Program or erase without write enable |
| warn_trunc_o | output | 1 | Frame ended inside the address phase |

## Verification
The bench aims at the byte-index boundaries: a design off by one at the fast-read dummy would report the dummy as data or drop the first data byte, and one that wraps the running address at the wrong width would show 0x1000000 truncated wrongly or never return to zero after 0xFFFFFF. It drives both reply orders of the manufacturer/device ID read, since a swapped selector test tags the device ID as manufacturer. It checks that the write-enable latch is consumed by the first erase, so a design that never clears it would stay silent on the second erase, and it ends a frame after one address byte to catch a monitor that forgets the partial command. An unsupported opcode followed by a valid one in the same frame exposes a design that stays stuck after the unknown byte.

// File: rtl/spimon_pkg.sv
package spimon_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_BE    = 8'hD8;
  localparam logic [7:0] OP_CE_A  = 8'h60;
  localparam logic [7:0] OP_CE_B  = 8'hC7;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_MDID  = 8'h90;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_WREN, CMD_WRDI, CMD_JEDEC, CMD_RDSR, CMD_WRSR,
    CMD_READ, CMD_FAST, CMD_SE, CMD_BE, CMD_CE, CMD_PP, CMD_MDID
  } cmd_e;

  localparam logic [1:0] ID_MANUF = 2'd0;
  localparam logic [1:0] ID_MTYPE = 2'd1;
  localparam logic [1:0] ID_DEV   = 2'd2;

endpackage

// File: rtl/spimon_decode.sv
module spimon_decode
  import spimon_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_e       cmd_o,
  output logic       known_o,
  output logic       wr_o
);
  always_comb begin
    unique case (op_i)
      OP_WREN:          cmd_o = CMD_WREN;
      OP_WRDI:          cmd_o = CMD_WRDI;
      OP_JEDEC:         cmd_o = CMD_JEDEC;
      OP_RDSR:          cmd_o = CMD_RDSR;
      OP_WRSR:          cmd_o = CMD_WRSR;
      OP_READ:          cmd_o = CMD_READ;
      OP_FAST:          cmd_o = CMD_FAST;
      OP_SE:            cmd_o = CMD_SE;
      OP_BE:            cmd_o = CMD_BE;
      OP_CE_A, OP_CE_B: cmd_o = CMD_CE;
      OP_PP:            cmd_o = CMD_PP;
      OP_MDID:          cmd_o = CMD_MDID;
      default:          cmd_o = CMD_NONE;
    endcase
    known_o = (cmd_o != CMD_NONE);
    wr_o    = (cmd_o inside {CMD_PP, CMD_SE, CMD_BE, CMD_CE});
  end
endmodule

// File: rtl/spimon_addr.sv
module spimon_addr #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              inc_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] addr_q;

  assign nxt_o  = {addr_q[ADDR_W-9:0], byte_i};
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clr_i)   addr_q <= '0;
    else if (shift_i) addr_q <= nxt_o;
    else if (inc_i)   addr_q <= addr_q + ADDR_W'(1);
  end
endmodule

// File: rtl/spi_flash_monitor.sv
module spi_flash_monitor
  import spimon_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SECTOR_LG = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        mosi_byte_i,
  input  logic [7:0]        miso_byte_i,
  output logic              op_vld_o,
  output logic [7:0]        op_o,
  output logic              unk_o,
  output logic              addr_vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              data_vld_o,
  output logic [7:0]        data_o,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic              id_vld_o,
  output logic [1:0]        id_sel_o,
  output logic [7:0]        id_o,
  output logic              stat_vld_o,
  output logic [7:0]        stat_o,
  output logic              warn_align_o,
  output logic              warn_wren_o,
  output logic              warn_trunc_o
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 4);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_ALAST = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_DUMMY = CNT_W'(ADDR_BYTES + 1);
  // manufacturer/device ID read byte positions (count of bytes already seen)
  localparam logic [CNT_W-1:0] CNT_ORDER = CNT_W'(3);
  localparam logic [CNT_W-1:0] CNT_ID0   = CNT_W'(4);
  localparam logic [CNT_W-1:0] CNT_ID1   = CNT_W'(5);
  localparam logic [CNT_W-1:0] CNT_JLAST = CNT_W'(3);

  logic [CNT_W-1:0]  cnt_q;
  cmd_e              cmd_q;
  logic              wel_q, manuf_first_q;

  cmd_e              dec_cmd;
  logic              dec_known, dec_wr;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;

  logic strobe, frame_end, is_op, addr_cmd, in_addr, addr_last, data_evt;
  logic cur_wr;

  spimon_decode u_dec (
    .op_i    (mosi_byte_i),
    .cmd_o   (dec_cmd),
    .known_o (dec_known),
    .wr_o    (dec_wr)
  );

  assign strobe    = byte_vld_i && cs_active_i;
  assign frame_end = !cs_active_i && (cnt_q != '0);
  assign is_op     = strobe && (cnt_q == '0);
  assign addr_cmd  = cmd_q inside {CMD_READ, CMD_FAST, CMD_PP, CMD_SE};
  assign cur_wr    = cmd_q inside {CMD_PP, CMD_SE, CMD_BE, CMD_CE};
  assign in_addr   = strobe && addr_cmd && (cnt_q != '0) && (cnt_q <= CNT_ALAST);
  assign addr_last = in_addr && (cnt_q == CNT_ALAST);

  always_comb begin
    data_evt = 1'b0;
    if (strobe) begin
      unique case (cmd_q)
        CMD_READ, CMD_PP: data_evt = (cnt_q > CNT_ALAST);
        CMD_FAST:         data_evt = (cnt_q > CNT_DUMMY);
        default:          data_evt = 1'b0;
      endcase
    end
  end

  spimon_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (frame_end),
    .shift_i (in_addr),
    .inc_i   (data_evt),
    .byte_i  (mosi_byte_i),
    .addr_o  (cur_addr),
    .nxt_o   (nxt_addr)
  );

  // frame sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= '0;
      cmd_q         <= CMD_NONE;
      wel_q         <= 1'b0;
      manuf_first_q <= 1'b1;
    end else if (frame_end) begin
      cnt_q <= '0;
      cmd_q <= CMD_NONE;
      if (cur_wr) wel_q <= 1'b0;
    end else if (is_op) begin
      cmd_q <= dec_cmd;
      cnt_q <= dec_known ? CNT_W'(1) : '0;
      if (dec_cmd == CMD_WREN) wel_q <= 1'b1;
      if (dec_cmd == CMD_WRDI) wel_q <= 1'b0;
    end else if (strobe) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      if (cmd_q == CMD_MDID && cnt_q == CNT_ORDER)
        manuf_first_q <= (mosi_byte_i == 8'h00);
    end
  end

  // event outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_vld_o     <= 1'b0;
      op_o         <= '0;
      unk_o        <= 1'b0;
      addr_vld_o   <= 1'b0;
      addr_o       <= '0;
      data_vld_o   <= 1'b0;
      data_o       <= '0;
      data_addr_o  <= '0;
      id_vld_o     <= 1'b0;
      id_sel_o     <= '0;
      id_o         <= '0;
      stat_vld_o   <= 1'b0;
      stat_o       <= '0;
      warn_align_o <= 1'b0;
      warn_wren_o  <= 1'b0;
      warn_trunc_o <= 1'b0;
    end else begin
      op_vld_o     <= is_op && dec_known;
      unk_o        <= is_op && !dec_known;
      warn_wren_o  <= is_op && dec_wr && !wel_q;
      if (is_op && dec_known) op_o <= mosi_byte_i;

      addr_vld_o   <= addr_last;
      warn_align_o <= addr_last && (cmd_q == CMD_SE) &&
                      (nxt_addr[SECTOR_LG-1:0] != '0);
      if (addr_last) addr_o <= nxt_addr;

      warn_trunc_o <= frame_end && addr_cmd && (cnt_q <= CNT_ALAST);

      data_vld_o <= data_evt;
      if (data_evt) begin
        data_o      <= (cmd_q == CMD_PP) ? mosi_byte_i : miso_byte_i;
        data_addr_o <= cur_addr;
      end

      stat_vld_o <= strobe && (cmd_q == CMD_RDSR) && (cnt_q != '0);
      if (strobe && cmd_q == CMD_RDSR) stat_o <= miso_byte_i;

      id_vld_o <= 1'b0;
      if (strobe && cmd_q == CMD_JEDEC && cnt_q != '0 && cnt_q <= CNT_JLAST) begin
        id_vld_o <= 1'b1;
        id_sel_o <= 2'(cnt_q - CNT_W'(1));
        id_o     <= miso_byte_i;
      end
      if (strobe && cmd_q == CMD_MDID && (cnt_q == CNT_ID0 || cnt_q == CNT_ID1)) begin
        id_vld_o <= 1'b1;
        id_sel_o <= ((cnt_q == CNT_ID0) == manuf_first_q) ? ID_MANUF : ID_DEV;
        id_o     <= miso_byte_i;
      end
    end
  end
endmodule

// File: rtl/spimon_chk.sv
module spimon_chk #(
  parameter int ADDR_W    = 24,
  parameter int SECTOR_LG = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_active_i,
  input logic              byte_vld_i,
  input logic              op_vld_o,
  input logic              unk_o,
  input logic              addr_vld_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              data_vld_o,
  input logic [ADDR_W-1:0] data_addr_o,
  input logic              warn_align_o,
  input logic              warn_trunc_o
);
  a_r1_op_from_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_vld_o |-> $past(byte_vld_i && cs_active_i));

  a_r2_op_or_unknown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_vld_o && unk_o));

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_o && $past(data_vld_o)) |-> (data_addr_o == $past(data_addr_o) + ADDR_W'(1)));

  a_r6_align_with_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_align_o |-> (addr_vld_o && (addr_o[SECTOR_LG-1:0] != '0)));

  a_r11_trunc_after_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_trunc_o |-> !$past(cs_active_i));

  a_r12_desel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !cs_active_i) |=> !(op_vld_o || unk_o || data_vld_o || addr_vld_o));
endmodule

bind spi_flash_monitor spimon_chk #(.ADDR_W(ADDR_W), .SECTOR_LG(SECTOR_LG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_active_i  (cs_active_i),
  .byte_vld_i   (byte_vld_i),
  .op_vld_o     (op_vld_o),
  .unk_o        (unk_o),
  .addr_vld_o   (addr_vld_o),
  .addr_o       (addr_o),
  .data_vld_o   (data_vld_o),
  .data_addr_o  (data_addr_o),
  .warn_align_o (warn_align_o),
  .warn_trunc_o (warn_trunc_o)
);

// File: tb/tb_spi_flash_monitor.sv
module tb_spi_flash_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, vld = 1'b0;
  logic [7:0]  mosi = '0, miso = '0;
  logic        op_vld, unk, addr_vld, data_vld, id_vld, stat_vld;
  logic        w_align, w_wren, w_trunc;
  logic [7:0]  op, data, id, stat;
  logic [1:0]  id_sel;
  logic [23:0] addr, data_addr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  spi_flash_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_active_i(cs), .byte_vld_i(vld),
    .mosi_byte_i(mosi), .miso_byte_i(miso),
    .op_vld_o(op_vld), .op_o(op), .unk_o(unk),
    .addr_vld_o(addr_vld), .addr_o(addr),
    .data_vld_o(data_vld), .data_o(data), .data_addr_o(data_addr),
    .id_vld_o(id_vld), .id_sel_o(id_sel), .id_o(id),
    .stat_vld_o(stat_vld), .stat_o(stat),
    .warn_align_o(w_align), .warn_wren_o(w_wren), .warn_trunc_o(w_trunc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one strobe in a selected frame; returns with its outputs visible
  task automatic send(input logic [7:0] m, input logic [7:0] s);
    @(negedge clk); cs = 1'b1; vld = 1'b1; mosi = m; miso = s;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic end_frame(input logic exp_trunc, input string req);
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    chk(req, "warn_trunc", w_trunc, exp_trunc);
  endtask

  task automatic t_reset;
    chk("R1", "op_vld at reset", op_vld, 0);
    chk("R3", "addr_vld at reset", addr_vld, 0);
    chk("R4", "data_vld at reset", data_vld, 0);
    chk("R11", "warn_trunc at reset", w_trunc, 0);
  endtask

  task automatic t_read;
    send(8'h03, 8'h00);
    chk("R1", "read op_vld", op_vld, 1); chk("R1", "read op", op, 8'h03);
    send(8'h12, 0); chk("R3", "no addr yet", addr_vld, 0);
    send(8'h34, 0); send(8'h56, 0);
    chk("R3", "read addr_vld", addr_vld, 1); chk("R3", "read addr", addr, 24'h123456);
    chk("R4", "no data at byte 4", data_vld, 0);
    send(8'hFF, 8'hA1);
    chk("R4", "read data_vld", data_vld, 1); chk("R4", "read data miso", data, 8'hA1);
    chk("R5", "read first data addr", data_addr, 24'h123456);
    send(8'hFF, 8'hA2);
    chk("R4", "read data 2", data, 8'hA2); chk("R5", "read data addr +1", data_addr, 24'h123457);
    end_frame(0, "R11");
  endtask

  task automatic t_fast_wrap;
    send(8'h0B, 0); send(8'hFF, 0); send(8'hFF, 0); send(8'hFF, 0);
    chk("R3", "fast addr", addr, 24'hFFFFFF);
    send(8'h00, 8'hEE);
    chk("R4", "fast dummy no data", data_vld, 0);
    send(8'h00, 8'h11);
    chk("R4", "fast data byte 6", data_vld, 1); chk("R4", "fast data", data, 8'h11);
    chk("R5", "fast addr top", data_addr, 24'hFFFFFF);
    send(8'h00, 8'h22);
    chk("R5", "fast addr wrap", data_addr, 24'h000000);
    end_frame(0, "R11");
  endtask

  task automatic t_pp_no_wren;
    send(8'h02, 0);
    chk("R7", "pp without wren warns", w_wren, 1);
    send(8'h00, 0); send(8'h01, 0); send(8'h00, 0);
    chk("R3", "pp addr", addr, 24'h000100);
    send(8'h5A, 8'hFF);
    chk("R4", "pp data from mosi", data, 8'h5A); chk("R5", "pp data addr", data_addr, 24'h000100);
    end_frame(0, "R11");
  endtask

  task automatic t_erase_latch;
    send(8'h06, 0); end_frame(0, "R11");
    send(8'h20, 0);
    chk("R7", "se after wren no warn", w_wren, 0);
    send(8'h00, 0); send(8'h10, 0); send(8'h00, 0);
    chk("R6", "aligned se addr_vld", addr_vld, 1); chk("R6", "aligned se no warn", w_align, 0);
    end_frame(0, "R11");
    send(8'h20, 0);
    chk("R7", "latch consumed by erase", w_wren, 1);
    send(8'h00, 0); send(8'h10, 0); send(8'h01, 0);
    chk("R6", "misaligned se warn", w_align, 1); chk("R3", "se addr", addr, 24'h001001);
    end_frame(0, "R11");
    send(8'h06, 0); end_frame(0, "R11");
    send(8'h04, 0); end_frame(0, "R11");
    send(8'hD8, 0);
    chk("R7", "wrdi clears latch", w_wren, 1);
    end_frame(0, "R11");
  endtask

  task automatic t_jedec;
    send(8'h9F, 0);
    send(0, 8'hC2); chk("R8", "jedec id0", {id_vld, id_sel, id}, {1'b1, 2'd0, 8'hC2});
    send(0, 8'h20); chk("R8", "jedec id1", {id_vld, id_sel, id}, {1'b1, 2'd1, 8'h20});
    send(0, 8'h16); chk("R8", "jedec id2", {id_vld, id_sel, id}, {1'b1, 2'd2, 8'h16});
    send(0, 8'h99); chk("R8", "jedec extra quiet", id_vld, 0);
    end_frame(0, "R11");
  endtask

  task automatic t_mdid(input logic [7:0] sel);
    logic [1:0] first;
    first = (sel == 8'h00) ? 2'd0 : 2'd2;
    send(8'h90, 0);
    send(0, 8'h77); chk("R9", "dummy quiet", id_vld, 0);
    send(0, 8'h77); send(sel, 8'h77); chk("R9", "selector quiet", id_vld, 0);
    send(0, 8'hC2); chk("R9", "first id", {id_vld, id_sel, id}, {1'b1, first, 8'hC2});
    send(0, 8'h15); chk("R9", "second id", {id_vld, id_sel, id}, {1'b1, 2'd2 - first, 8'h15});
    end_frame(0, "R11");
  endtask

  task automatic t_status;
    send(8'h05, 0);
    chk("R10", "no status at opcode", stat_vld, 0);
    send(0, 8'h02); chk("R10", "status 1", {stat_vld, stat}, {1'b1, 8'h02});
    for (int i = 0; i < 8; i++) send(0, 8'(i + 8'h40));
    chk("R10", "status keeps flowing", {stat_vld, stat}, {1'b1, 8'h47});
    end_frame(0, "R11");
  endtask

  task automatic t_unknown_trunc;
    send(8'hAB, 0);
    chk("R2", "unknown flagged", unk, 1); chk("R2", "unknown no op", op_vld, 0);
    send(8'h03, 0);
    chk("R2", "reopcode same frame", {op_vld, op}, {1'b1, 8'h03});
    send(8'h12, 0);
    end_frame(1, "R11");
    send(8'h02, 0); send(1, 0); send(2, 0); send(3, 0);
    end_frame(0, "R11");
  endtask

  task automatic t_desel;
    @(negedge clk); cs = 1'b0; vld = 1'b1; mosi = 8'h03;
    @(negedge clk); vld = 1'b0;
    chk("R12", "deselected opcode ignored", {op_vld, unk}, 2'b00);
    send(8'h03, 0);
    chk("R12", "next frame opcode", op_vld, 1);
    send(8'hAA, 0); send(8'hBB, 0); send(8'hCC, 0);
    chk("R12", "addr after ignored strobe", addr, 24'hAABBCC);
    end_frame(0, "R11");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_fast_wrap();
    t_pp_no_wren();
    t_erase_latch();
    t_jedec();
    t_mdid(8'h00);
    t_mdid(8'h01);
    t_status();
    t_unknown_trunc();
    t_desel();
    finish_run();
  end
endmodule